// File: doc/BRIEF.md
# Variable-Length Microcycle Timing Generator

The block generates the microcycle clock for a microprogrammed processor. It runs on a fast reference clock, and each rising edge of that clock is one tick (20 ns by default). Each microinstruction picks one of three microcycle lengths: short (140 ns), medium (200 ns) or long (300 ns). The generator counts that many ticks and pulses `ucyc_end` on the final tick of the microcycle. The sequencer advances to the next microinstruction on that pulse.

A microinstruction that starts a bus transfer raises `bus_req` on its first tick. After that microcycle's counted period ends, the generator freezes in a halted state. It stays there until the bus raises `bus_done`, and the next microcycle starts on the following tick. An elapsed-tick accumulator counts every tick, stalled ticks included. It restarts on `instr_start`, so the time taken by a macroinstruction can be read as the sum of its microcycle lengths plus its bus stalls.

The controller has two named states:
- `ST_RUN` counts ticks.
- `ST_STALL` waits for the bus.

It has two named transitions:
- `ST_RUN`→`ST_STALL` (enter stall) fires on the last tick of a microcycle that latched a bus request.
- `ST_STALL`→`ST_RUN` (resume) fires on a tick with `bus_done` high.

Top module: `ucyc_timing_gen`

## Requirements
- R1: The code on `len_sel` selects the microcycle length: 2'b00 gives 7 ticks, 2'b01 gives 10 ticks, 2'b10 gives 15 ticks, and 2'b11 is treated as 7 ticks. `ucyc_end` is high on exactly one tick per microcycle, the last one.
- R2: `len_sel` is sampled only on the first tick of a microcycle. Changing it later in that microcycle has no effect on its length.
- R3: `bus_req` is sampled only on the first tick. If it was high, `halted` is high on the tick after the `ucyc_end` tick. If it was low, `halted` stays low, even if `bus_req` changes later in the microcycle.
- R4: While `halted` is high, `ucyc_end` stays low, the tick count is frozen, and `halted` stays high until `bus_done` is seen.
- R5: A tick that is halted and has `bus_done` high is followed by the first tick of the next microcycle, with `halted` low. `bus_done` is ignored while the generator is running.
- R6: `elapsed` increases by one on every tick, whether halted or running.
- R7: A tick with `instr_start` high loads `elapsed` with 1, so that tick is counted. After an instruction of T ticks, `elapsed` reads T on the first tick that follows it.
- R8: After synchronous reset, `halted` is 0, `ucyc_end` is 0 and `elapsed` is 0, and the next tick is the first tick of a microcycle.
- R9: For the three jump sequences, the ticks an instruction takes equal the sum of its microcycle lengths plus the ticks spent stalled:
  - register-deferred: 7,7,10,7 then 10,7,10,7, with one stall
  - autoincrement: the same fetch steps then 15,10,7,10,7, with one stall
  - autoincrement-deferred: the same fetch steps then 15,7,10,7, with two stalls

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; each rising edge is one tick |
| rst | input | 1 | Synchronous active-high reset |
| len_sel | input | 2 | Length code of the current microinstruction |
| bus_req | input | 1 | The current microinstruction starts a bus transfer |
| bus_done | input | 1 | The bus transfer has completed |
| instr_start | input | 1 | First tick of a new macroinstruction; restarts `elapsed` |
| ucyc_end | output | 1 | End-of-microcycle strobe, high on the final tick |
| halted | output | 1 | Microcycle clock frozen, waiting for the bus |
| elapsed | output | 16 | Ticks since the last `instr_start` |

## Verification
Two functions share cycles in this block, and the bench provokes both.

The first is the instruction restart and the sampling of a microcycle's length and bus request. The bench raises `instr_start` on the same tick that latches the first fetch step's code and bus flag. It then judges that `elapsed` reads 1 one tick later, that the step still has its own length, and that the stall still happens.

The second is stall entry and resume. A random stall length may be a single tick, so `bus_done` can arrive on the very first halted tick. A scoreboard of expected microcycle lengths, and the instruction totals, show that exactly one tick was lost to that stall and that the next microcycle started on time.

// File: rtl/ucyc_pkg.sv
package ucyc_pkg;

    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_STALL = 1'b1
    } ucyc_state_e;

    typedef enum logic [1:0] {
        LEN_SHORT = 2'b00,
        LEN_MED   = 2'b01,
        LEN_LONG  = 2'b10,
        LEN_ALT   = 2'b11
    } ucyc_len_e;

endpackage

// File: rtl/ucyc_len_decode.sv
module ucyc_len_decode
    import ucyc_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter int T_SHORT = 7,
    parameter int T_MED   = 10,
    parameter int T_LONG  = 15
) (
    input  logic [1:0]       code,
    output logic [CNT_W-1:0] term
);

    // Map each length code to the number of ticks in the microcycle.
    always_comb begin
        unique case (ucyc_len_e'(code))
            LEN_SHORT: term = CNT_W'(T_SHORT);
            LEN_MED:   term = CNT_W'(T_MED);
            LEN_LONG:  term = CNT_W'(T_LONG);
            LEN_ALT:   term = CNT_W'(T_SHORT);
            default:   term = CNT_W'(T_SHORT);
        endcase
    end

endmodule

// File: rtl/ucyc_tick_counter.sv
module ucyc_tick_counter #(
    parameter int CNT_W   = 4,
    parameter int T_RESET = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] term_in,
    output logic             first_tick,
    output logic             last_tick
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] term_q;

    // The length is latched on the first tick and used for the rest of the microcycle.
    always_comb begin
        first_tick = run && (cnt_q == '0);
        last_tick  = run && (cnt_q != '0) && (cnt_q == term_q - ONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            term_q <= CNT_W'(T_RESET);
        end else if (run) begin
            if (first_tick) begin
                term_q <= term_in;
            end
            if (last_tick) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + ONE;
            end
        end
    end

    a_r4_count_frozen: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(cnt_q));

    a_r2_length_held: assert property (@(posedge clk) disable iff (rst)
        !first_tick |=> $stable(term_q));

    a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q < term_q);

endmodule

// File: rtl/ucyc_stall_fsm.sv
module ucyc_stall_fsm
    import ucyc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic first_tick,
    input  logic last_tick,
    input  logic bus_req,
    input  logic bus_done,
    output logic run,
    output logic halted
);

    ucyc_state_e state_q;
    ucyc_state_e state_d;
    logic        pend_q;

    // State register and the bus request latched on the first tick.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (first_tick) begin
                pend_q <= bus_req;
            end
        end
    end

    // Next-state logic: enter stall and resume.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (last_tick && pend_q) state_d = ST_STALL;
            ST_STALL: if (bus_done)            state_d = ST_RUN;
            default:                           state_d = ST_RUN;
        endcase
    end

    // State outputs.
    always_comb begin
        halted = (state_q == ST_STALL);
        run    = !halted;
    end

    a_r3_enter_stall: assert property (@(posedge clk) disable iff (rst)
        (last_tick && pend_q) |=> halted);

    a_r3_no_stall: assert property (@(posedge clk) disable iff (rst)
        (last_tick && !pend_q) |=> !halted);

    a_r4_wait_bus: assert property (@(posedge clk) disable iff (rst)
        (halted && !bus_done) |=> halted);

    a_r5_resume: assert property (@(posedge clk) disable iff (rst)
        (halted && bus_done) |=> (!halted && first_tick));

endmodule

// File: rtl/ucyc_elapsed.sv
module ucyc_elapsed #(
    parameter int ELAPSED_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 instr_start,
    output logic [ELAPSED_W-1:0] elapsed
);

    localparam logic [ELAPSED_W-1:0] ONE = ELAPSED_W'(1);

    // The tick carrying the start pulse counts as the instruction's first tick.
    always_ff @(posedge clk) begin
        if (rst) begin
            elapsed <= '0;
        end else if (instr_start) begin
            elapsed <= ONE;
        end else begin
            elapsed <= elapsed + ONE;
        end
    end

    a_r6_step: assert property (@(posedge clk) disable iff (rst)
        !instr_start |=> (elapsed == $past(elapsed) + ONE));

    a_r7_restart: assert property (@(posedge clk) disable iff (rst)
        instr_start |=> (elapsed == ONE));

endmodule

// File: rtl/ucyc_timing_gen.sv
module ucyc_timing_gen #(
    parameter int TICK_NS   = 20,
    parameter int SHORT_NS  = 140,
    parameter int MED_NS    = 200,
    parameter int LONG_NS   = 300,
    parameter int ELAPSED_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           len_sel,
    input  logic                 bus_req,
    input  logic                 bus_done,
    input  logic                 instr_start,
    output logic                 ucyc_end,
    output logic                 halted,
    output logic [ELAPSED_W-1:0] elapsed
);

    localparam int T_SHORT = SHORT_NS / TICK_NS;
    localparam int T_MED   = MED_NS / TICK_NS;
    localparam int T_LONG  = LONG_NS / TICK_NS;
    localparam int CNT_W   = $clog2(T_LONG + 1);

    logic [CNT_W-1:0] term;
    logic             run;
    logic             first_tick;
    logic             last_tick;

    ucyc_len_decode #(
        .CNT_W  (CNT_W),
        .T_SHORT(T_SHORT),
        .T_MED  (T_MED),
        .T_LONG (T_LONG)
    ) u_decode (
        .code(len_sel),
        .term(term)
    );

    ucyc_tick_counter #(
        .CNT_W  (CNT_W),
        .T_RESET(T_SHORT)
    ) u_counter (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .term_in   (term),
        .first_tick(first_tick),
        .last_tick (last_tick)
    );

    ucyc_stall_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .first_tick(first_tick),
        .last_tick (last_tick),
        .bus_req   (bus_req),
        .bus_done  (bus_done),
        .run       (run),
        .halted    (halted)
    );

    ucyc_elapsed #(
        .ELAPSED_W(ELAPSED_W)
    ) u_elapsed (
        .clk        (clk),
        .rst        (rst),
        .instr_start(instr_start),
        .elapsed    (elapsed)
    );

    assign ucyc_end = last_tick;

    a_r4_no_strobe_halted: assert property (@(posedge clk) disable iff (rst)
        halted |-> !ucyc_end);

endmodule

// File: tb/ucyc_timing_gen_test.sv
module ucyc_timing_gen_test;

    localparam int CLK_PERIOD = 20;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  len_sel = 2'b00;
    logic        bus_req = 1'b0;
    logic        bus_done = 1'b0;
    logic        instr_start = 1'b0;
    logic        ucyc_end;
    logic        halted;
    logic [15:0] elapsed;

    int checks = 0;
    int errors = 0;
    int acc    = 0;
    int ticks  = 0;
    int exp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    ucyc_timing_gen uut (
        .clk        (clk),
        .rst        (rst),
        .len_sel    (len_sel),
        .bus_req    (bus_req),
        .bus_done   (bus_done),
        .instr_start(instr_start),
        .ucyc_end   (ucyc_end),
        .halted     (halted),
        .elapsed    (elapsed)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int len_ticks(input logic [1:0] code);
        case (code)
            2'b01:   return 10;
            2'b10:   return 15;
            default: return 7;
        endcase
    endfunction

    // Monitor: counts running ticks and compares each microcycle to the scoreboard.
    always @(negedge clk) begin
        if (rst) begin
            ticks = 0;
        end else begin
            if (!halted) ticks++;
            if (ucyc_end) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1 unexpected strobe", ticks, 0);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(ticks == e, "R1 R2 microcycle length", ticks, e);
                end
                ticks = 0;
            end
        end
    end

    // Driver: one microcycle, entered and left at the negedge of a first tick.
    task automatic run_uc(input logic [1:0] code, input bit req, input int stall,
                          input bit wiggle, input bit start);
        int n;
        n = len_ticks(code);
        len_sel = code;
        bus_req = req;
        instr_start = start;
        if (start) acc = 0;
        acc += n;
        exp_q.push_back(n);
        @(negedge clk);
        instr_start = 1'b0;
        if (start) check(elapsed == 16'd1, "R7 restart value", elapsed, 1);
        if (wiggle) begin
            len_sel  = ~code;
            bus_req  = ~req;
            bus_done = 1'b1;
        end
        while (!ucyc_end) @(negedge clk);
        bus_done = 1'b0;
        @(negedge clk);
        check(halted == req, "R3 halted after strobe", halted, req);
        if (req) begin
            for (int i = 1; i < stall; i++) begin
                check(halted && !ucyc_end, "R4 frozen while halted", ucyc_end, 0);
                @(negedge clk);
            end
            check(halted, "R4 still halted", halted, 1);
            bus_done = 1'b1;
            @(negedge clk);
            bus_done = 1'b0;
            acc += stall;
            check(!halted, "R5 resume after bus done", halted, 0);
        end
    endtask

    task automatic fetch(input int s0);
        run_uc(2'b00, 1'b1, s0, 1'b0, 1'b1);
        run_uc(2'b00, 1'b0, 0, 1'b0, 1'b0);
        run_uc(2'b01, 1'b0, 0, 1'b0, 1'b0);
        run_uc(2'b00, 1'b0, 0, 1'b0, 1'b0);
    endtask

    task automatic end_instr(input int micro_sum, input int stalls, input string tag);
        check(acc == micro_sum + stalls, tag, acc, micro_sum + stalls);
        check(elapsed == acc, "R6 R7 R9 elapsed total", elapsed, acc);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=0", WATCHDOG);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int s1;
        int s2;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: state under reset
        check(halted == 1'b0, "R8 halted after reset", halted, 0);
        check(ucyc_end == 1'b0, "R8 strobe after reset", ucyc_end, 0);
        check(elapsed == 16'd0, "R8 elapsed after reset", elapsed, 0);
        @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);

        for (int rep = 0; rep < 4; rep++) begin
            // R9: register-deferred jump, 65 ticks plus one stall
            s1 = (rep == 0) ? 1 : int'($urandom_range(1, 12));
            fetch(s1);
            run_uc(2'b01, 1'b0, 0, 1'b0, 1'b0);
            run_uc(2'b00, 1'b0, 0, 1'b0, 1'b0);
            run_uc(2'b01, 1'b0, 0, 1'b0, 1'b0);
            run_uc(2'b00, 1'b0, 0, 1'b0, 1'b0);
            end_instr(65, s1, "R9 mode1 total");

            // R9: autoincrement jump, 80 ticks plus one stall
            s1 = int'($urandom_range(1, 12));
            fetch(s1);
            run_uc(2'b10, 1'b0, 0, 1'b0, 1'b0);
            run_uc(2'b01, 1'b0, 0, 1'b0, 1'b0);
            run_uc(2'b00, 1'b0, 0, 1'b0, 1'b0);
            run_uc(2'b01, 1'b0, 0, 1'b0, 1'b0);
            run_uc(2'b00, 1'b0, 0, 1'b0, 1'b0);
            end_instr(80, s1, "R9 mode2 total");

            // R9: autoincrement-deferred jump, 70 ticks plus two stalls
            s1 = int'($urandom_range(1, 12));
            s2 = (rep == 1) ? 1 : int'($urandom_range(1, 12));
            fetch(s1);
            run_uc(2'b10, 1'b1, s2, 1'b0, 1'b0);
            run_uc(2'b00, 1'b0, 0, 1'b0, 1'b0);
            run_uc(2'b01, 1'b0, 0, 1'b0, 1'b0);
            run_uc(2'b00, 1'b0, 0, 1'b0, 1'b0);
            end_instr(70, s1 + s2, "R9 mode3 total");
        end

        // R1: code 11 counts as short; R2/R3/R5: late input changes ignored
        run_uc(2'b11, 1'b0, 0, 1'b0, 1'b1);
        run_uc(2'b10, 1'b0, 0, 1'b1, 1'b0);
        run_uc(2'b00, 1'b1, 3, 1'b1, 1'b0);
        run_uc(2'b01, 1'b0, 0, 1'b1, 1'b0);
        run_uc(2'b11, 1'b1, 2, 1'b0, 1'b0);
        end_instr(7 + 15 + 7 + 10 + 7, 5, "R1 R2 R5 mixed total");

        check(exp_q.size() == 0, "R1 strobes matched", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule